// File: doc/BRIEF.md
# Coincident-Current Core Store Sequencer

This block runs accesses to a word-organised magnetic core store in which reading destroys the stored word. Each access is a two-phase cycle. A clearing pass drives the addressed X and Y lines in the reset direction. The cores that held a one flip, and they report on their plane's sense line. A set pass then drives the same lines in the set direction. Each plane whose target bit is zero raises its inhibit line, so its core stays cleared. The store has no write-enable: zeros come from inhibit alone.

A read writes the sensed word back. A write clears the word, discards what was sensed and stores the host's word. A read-modify-write hands the old word to the host after the clearing pass. It then waits a modify gap, takes the host's new word at the end of that gap and stores it. The behavioural core planes sit inside the block. Their select, direction and inhibit drives are also brought out as outputs so the drive sequence can be observed. The lengths of the clearing pass, the modify gap and the set pass are parameters counted in clock cycles.

Top module: `ccm_top`

## Requirements
- R1: In the clearing pass, `drv_reset` is high for T_RD cycles. During it, `x_drive` is one-hot with bit `addr[XW-1:0]` set and `y_drive` is one-hot with bit `addr[AW-1:XW]` set.
- R2: After a read (op 0, with op 3 treated the same), `rdata` holds the word last stored at that address once `done` has pulsed.
- R3: A read leaves the stored word unchanged, so a second read of the same address returns the same word.
- R4: In the set pass, `drv_set` is high for T_WR cycles, and `inhibit[p]` is high exactly for the planes whose target bit is 0. Inhibit is never high outside the set pass.
- R5: A write (op 1) still runs the clearing pass, discards the sensed word and stores `wdata` as sampled with `start`.
- R6: In a read-modify-write (op 2), `rdata` carries the old word from the end of the clearing pass. The word stored is `wdata` as sampled in the last cycle of the modify gap, not its value at `start`.
- R7: `busy` stays high for T_RD+T_WR+2 cycles for reads and writes, and for T_RD+T_GAP+T_WR+1 cycles for read-modify-write. With the defaults this is 12 against 14.
- R8: `done` is high for exactly one cycle, the last cycle in which `busy` is high. `busy` does not drop before `done`.
- R9: `drv_set` and `drv_reset` are never high together. At least one cycle with all drives idle separates the two passes.
- R10: A `start` while `busy` is high is ignored. The running access finishes unchanged and no second access follows.
- R11: In the core planes, a core changes state only when both its X line and its Y line are driven. A half-selected core, or a selected core whose plane's inhibit is high during a set drive, keeps its state.
- R12: After reset, `busy`, `done`, `drv_set`, `drv_reset`, `x_drive`, `y_drive` and `inhibit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an access; sampled only when idle |
| op | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 read |
| addr | input | XW+YW | Word address; low XW bits pick the X line, high YW bits the Y line |
| wdata | input | DW | New word (sampled at start for writes, end of gap for read-modify-write) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse in the final busy cycle |
| rdata | output | DW | Word sensed by the latest clearing pass |
| x_drive | output | 2**XW | One-hot X select drive |
| y_drive | output | 2**YW | One-hot Y select drive |
| drv_reset | output | 1 | Select drives in the clearing direction |
| drv_set | output | 1 | Select drives in the setting direction |
| inhibit | output | DW | Per-plane inhibit drive |

## Verification
The checker watches several rules on every cycle: that the select drives are one-hot, that the two directions never overlap, that an idle cycle separates the passes, that inhibit appears only with a set drive, the shape of `busy` and `done`, and the exact length of each kind of access. Only the bench's sweeps can show that data survives. These sweeps cover the destructive read followed by write-back, writes over earlier contents, the late capture of the read-modify-write word, the all-zero and all-one words, and a start that arrives mid-access. A bench-driven copy of the plane model shows that half-selected and inhibited cores hold their state.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RMW   = 2'd2,
    OP_READ2 = 2'd3
  } ccm_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_QUIET,
    ST_MOD,
    ST_SET,
    ST_DONE
  } ccm_state_e;
endpackage

// File: rtl/ccm_onehot.sv
module ccm_onehot #(
  parameter int W = 6,
  localparam int N = 1 << W
) (
  input  logic [W-1:0] idx,
  input  logic         en,
  output logic [N-1:0] sel
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign sel[i] = en && (idx == W'(i));
  end
endmodule

// File: rtl/ccm_planes.sv
module ccm_planes #(
  parameter int XW = 6,
  parameter int YW = 6,
  parameter int DW = 12,
  localparam int NX = 1 << XW,
  localparam int NY = 1 << YW,
  localparam int AW = XW + YW
) (
  input  logic          clk,
  input  logic [NX-1:0] x_sel,
  input  logic [NY-1:0] y_sel,
  input  logic          drv_reset,
  input  logic          drv_set,
  input  logic [DW-1:0] inhibit,
  output logic [DW-1:0] sense
);
  logic [DW-1:0] core_mem [NX*NY];
  logic [XW-1:0] xi;
  logic [YW-1:0] yi;
  logic          hit;
  logic [AW-1:0] idx;

  always_comb begin
    xi = '0;
    yi = '0;
    for (int i = 0; i < NX; i++) if (x_sel[i]) xi = XW'(i);
    for (int j = 0; j < NY; j++) if (y_sel[j]) yi = YW'(j);
  end

  assign hit   = (|x_sel) && (|y_sel);
  assign idx   = {yi, xi};
  assign sense = (hit && drv_reset) ? core_mem[idx] : '0;

  always_ff @(posedge clk) begin
    if (hit && drv_reset) begin
      core_mem[idx] <= '0;
    end else if (hit && drv_set) begin
      core_mem[idx] <= core_mem[idx] | ~inhibit;
    end
  end
endmodule

// File: rtl/ccm_seq.sv
module ccm_seq
  import ccm_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 12,
  parameter int T_RD  = 5,
  parameter int T_GAP = 3,
  parameter int T_WR  = 5,
  localparam int TMAX = (T_RD > T_WR) ? ((T_RD > T_GAP) ? T_RD : T_GAP)
                                      : ((T_WR > T_GAP) ? T_WR : T_GAP),
  localparam int CW   = $clog2(TMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] sense,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] addr_q,
  output logic          line_en,
  output logic          drv_reset,
  output logic          drv_set,
  output logic [DW-1:0] inhibit
);
  ccm_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    op_q;
  logic [DW-1:0] acc_q, acc_d;
  logic [DW-1:0] wb_q, wb_d;
  logic [DW-1:0] rdata_d;
  logic          accept, last, rd_end, mod_end;

  assign accept  = (st_q == ST_IDLE) && start;
  assign last    = (cnt_q == '0);
  assign rd_end  = (st_q == ST_CLEAR) && last;
  assign mod_end = (st_q == ST_MOD) && last;

  always_comb begin
    st_d  = st_q;
    cnt_d = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    case (st_q)
      ST_IDLE:  if (start) begin st_d = ST_CLEAR; cnt_d = CW'(T_RD - 1); end
      ST_CLEAR: if (last) begin
                  if (op_q == OP_RMW) begin st_d = ST_MOD; cnt_d = CW'(T_GAP - 1); end
                  else st_d = ST_QUIET;
                end
      ST_QUIET: begin st_d = ST_SET; cnt_d = CW'(T_WR - 1); end
      ST_MOD:   if (last) begin st_d = ST_SET; cnt_d = CW'(T_WR - 1); end
      ST_SET:   if (last) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    acc_d   = acc_q;
    wb_d    = wb_q;
    rdata_d = rdata;
    if (accept) begin
      acc_d = '0;
      if (op == OP_WRITE) wb_d = wdata;
    end else if (st_q == ST_CLEAR) begin
      acc_d = acc_q | sense;
    end
    if (rd_end) begin
      rdata_d = acc_q | sense;
      if (op_q != OP_WRITE) wb_d = acc_q | sense;
    end
    if (mod_end) wb_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      op_q   <= OP_READ;
      addr_q <= '0;
      acc_q  <= '0;
      wb_q   <= '0;
      rdata  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      acc_q <= acc_d;
      wb_q  <= wb_d;
      rdata <= rdata_d;
      if (accept) begin
        op_q   <= op;
        addr_q <= addr;
      end
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_DONE);
  assign drv_reset = (st_q == ST_CLEAR);
  assign drv_set   = (st_q == ST_SET);
  assign line_en   = drv_reset || drv_set;
  assign inhibit   = drv_set ? ~wb_q : '0;
endmodule

// File: rtl/ccm_top.sv
module ccm_top #(
  parameter int XW    = 6,
  parameter int YW    = 6,
  parameter int DW    = 12,
  parameter int T_RD  = 5,
  parameter int T_GAP = 3,
  parameter int T_WR  = 5,
  localparam int AW   = XW + YW,
  localparam int NX   = 1 << XW,
  localparam int NY   = 1 << YW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [NX-1:0] x_drive,
  output logic [NY-1:0] y_drive,
  output logic          drv_reset,
  output logic          drv_set,
  output logic [DW-1:0] inhibit
);
  logic [1:0]    rst_pipe;
  logic          rst_s;
  logic [AW-1:0] addr_q;
  logic          line_en;
  logic [DW-1:0] sense;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  ccm_seq #(.AW(AW), .DW(DW), .T_RD(T_RD), .T_GAP(T_GAP), .T_WR(T_WR)) i_seq (
    .clk(clk), .rst_n(rst_s), .start(start), .op(op), .addr(addr), .wdata(wdata),
    .sense(sense), .busy(busy), .done(done), .rdata(rdata), .addr_q(addr_q),
    .line_en(line_en), .drv_reset(drv_reset), .drv_set(drv_set), .inhibit(inhibit)
  );

  ccm_onehot #(.W(XW)) i_xdec (.idx(addr_q[XW-1:0]),  .en(line_en), .sel(x_drive));
  ccm_onehot #(.W(YW)) i_ydec (.idx(addr_q[AW-1:XW]), .en(line_en), .sel(y_drive));

  ccm_planes #(.XW(XW), .YW(YW), .DW(DW)) i_planes (
    .clk(clk), .x_sel(x_drive), .y_sel(y_drive), .drv_reset(drv_reset),
    .drv_set(drv_set), .inhibit(inhibit), .sense(sense)
  );
endmodule

// File: rtl/ccm_check.sv
module ccm_check
  import ccm_pkg::*;
#(
  parameter int NX    = 64,
  parameter int NY    = 64,
  parameter int DW    = 12,
  parameter int T_RD  = 5,
  parameter int T_GAP = 3,
  parameter int T_WR  = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    op,
  input logic          busy,
  input logic          done,
  input logic [NX-1:0] x_drive,
  input logic [NY-1:0] y_drive,
  input logic          drv_reset,
  input logic          drv_set,
  input logic [DW-1:0] inhibit
);
  int unsigned len_q;
  logic        rmw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= 0;
      rmw_q <= 1'b0;
    end else if (start && !busy) begin
      len_q <= 1;
      rmw_q <= (op == OP_RMW);
    end else if (busy) begin
      len_q <= len_q + 1;
    end
  end

  p_onehot_x_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(x_drive));
  p_onehot_y_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(y_drive));
  p_lines_with_dir_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_reset || drv_set) |-> ($countones(x_drive) == 1 && $countones(y_drive) == 1));
  p_inhibit_only_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|inhibit) |-> drv_set);
  p_dir_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_reset && drv_set));
  p_idle_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drv_reset |=> !drv_set);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  p_cycle_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (len_q == (rmw_q ? 32'(T_RD + T_GAP + T_WR + 1) : 32'(T_RD + T_WR + 2))));
endmodule

bind ccm_top ccm_check #(
  .NX(NX), .NY(NY), .DW(DW), .T_RD(T_RD), .T_GAP(T_GAP), .T_WR(T_WR)
) i_ccm_check (
  .clk(clk), .rst_n(rst_s), .start(start), .op(op), .busy(busy), .done(done),
  .x_drive(x_drive), .y_drive(y_drive), .drv_reset(drv_reset),
  .drv_set(drv_set), .inhibit(inhibit)
);

// File: tb/test_ccm_top.sv
module test_ccm_top;
  localparam int XW = 2, YW = 2, DW = 8;
  localparam int T_RD = 3, T_GAP = 2, T_WR = 2;
  localparam int NX = 1 << XW, NY = 1 << YW, NW = NX * NY, AW = XW + YW;
  localparam int LEN_PLAIN = T_RD + T_WR + 2;
  localparam int LEN_RMW   = T_RD + T_GAP + T_WR + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic busy, done, drv_reset, drv_set;
  logic [DW-1:0] rdata, inhibit;
  logic [NX-1:0] x_drive;
  logic [NY-1:0] y_drive;

  logic [NX-1:0] px = '0;
  logic [NY-1:0] py = '0;
  logic prst = 1'b0, pset = 1'b0;
  logic [DW-1:0] pinh = '0;
  logic [DW-1:0] psense;

  int checks = 0, errors = 0, cyc = 0;
  logic [DW-1:0] model [NW];
  logic [NX-1:0] first_x;
  logic [NY-1:0] first_y;
  logic first_rst;
  int rst_cnt, set_cnt, inh_bad, quiet_ok;
  logic [DW-1:0] set_inh;

  always #5 clk = ~clk;

  ccm_top #(.XW(XW), .YW(YW), .DW(DW), .T_RD(T_RD), .T_GAP(T_GAP), .T_WR(T_WR)) i_ccm_top (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .wdata(wdata),
    .busy(busy), .done(done), .rdata(rdata), .x_drive(x_drive), .y_drive(y_drive),
    .drv_reset(drv_reset), .drv_set(drv_set), .inhibit(inhibit)
  );

  ccm_planes #(.XW(XW), .YW(YW), .DW(DW)) i_pl (
    .clk(clk), .x_sel(px), .y_sel(py), .drv_reset(prst), .drv_set(pset),
    .inhibit(pinh), .sense(psense)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'(a * 37 + k * 91 + 5);
  endfunction

  task automatic access(input logic [1:0] o, input int a, input logic [DW-1:0] wd,
                        input logic [DW-1:0] wd_late, output int len);
    logic prev_rst;
    @(negedge clk);
    start = 1'b1; op = o; addr = AW'(a); wdata = wd;
    @(negedge clk);
    start = 1'b0;
    len = 0; rst_cnt = 0; set_cnt = 0; inh_bad = 0; quiet_ok = 0; prev_rst = 1'b0;
    forever begin
      if (busy) len++;
      if (len == 1) begin first_x = x_drive; first_y = y_drive; first_rst = drv_reset; end
      if (drv_reset) rst_cnt++;
      if (drv_set) begin set_cnt++; set_inh = inhibit; end
      if (!drv_set && inhibit != '0) inh_bad++;
      if (prev_rst && !drv_reset && !drv_set && x_drive == '0) quiet_ok = 1;
      prev_rst = drv_reset;
      if (o == 2'd2) wdata = wd_late;
      if (done) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy && !done, "R12 busy/done idle", {busy, done}, 0);
    chk(!drv_set && !drv_reset && x_drive == '0 && y_drive == '0 && inhibit == '0,
        "R12 drives idle", {drv_set, drv_reset, x_drive, y_drive}, 0);

    // R5 fill every word with writes; R1, R4, R7, R9 drive shape
    for (int a = 0; a < NW; a++) begin
      model[a] = pat(a, 0);
      access(2'd1, a, model[a], '0, len);
      chk(len == LEN_PLAIN, "R7 write length", len, LEN_PLAIN);
      chk(first_rst && first_x == NX'(1 << (a % NX)) && first_y == NY'(1 << (a / NX)),
          "R1 clearing drive lines", {first_rst, first_x, first_y},
          {1'b1, NX'(1 << (a % NX)), NY'(1 << (a / NX))});
      chk(rst_cnt == T_RD, "R1 clearing length", rst_cnt, T_RD);
      chk(set_cnt == T_WR && set_inh == ~model[a], "R4 set pass inhibit", set_inh, ~model[a]);
      chk(inh_bad == 0, "R4 inhibit outside set", inh_bad, 0);
      chk(quiet_ok == 1, "R9 idle cycle between passes", quiet_ok, 1);
    end

    // R2, R3, R11 op encoding: read twice, alternating op 0 and op 3
    for (int a = 0; a < NW; a++) begin
      access((a % 2) ? 2'd3 : 2'd0, a, 8'h5A, '0, len);
      chk(rdata == model[a], "R2 read returns stored word", rdata, model[a]);
      chk(len == LEN_PLAIN, "R7 read length", len, LEN_PLAIN);
      chk(set_inh == ~model[a], "R3 write-back inhibit", set_inh, ~model[a]);
      access(2'd0, a, 8'hC3, '0, len);
      chk(rdata == model[a], "R3 second read after write-back", rdata, model[a]);
    end

    // R6 read-modify-write, new word taken late
    for (int a = 0; a < NW; a++) begin
      logic [DW-1:0] nw;
      nw = pat(a, 1);
      access(2'd2, a, ~nw, nw, len);
      chk(rdata == model[a], "R6 old word presented", rdata, model[a]);
      chk(len == LEN_RMW, "R7 rmw length", len, LEN_RMW);
      model[a] = nw;
    end
    for (int a = 0; a < NW; a++) begin
      access(2'd0, a, '0, '0, len);
      chk(rdata == model[a], "R6 late word stored", rdata, model[a]);
    end

    // R5 / R4 extreme words: all ones then all zeros
    access(2'd1, 3, 8'hFF, '0, len);
    chk(set_inh == 8'h00, "R4 all-ones no inhibit", set_inh, 0);
    access(2'd0, 3, '0, '0, len);
    chk(rdata == 8'hFF, "R5 all-ones stored", rdata, 8'hFF);
    access(2'd1, 3, 8'h00, '0, len);
    chk(set_inh == 8'hFF, "R4 all-zero full inhibit", set_inh, 8'hFF);
    access(2'd0, 3, '0, '0, len);
    chk(rdata == 8'h00, "R5 all-zero stored", rdata, 0);
    model[3] = 8'h00;

    // R10 start during busy ignored
    @(negedge clk);
    start = 1'b1; op = 2'd0; addr = AW'(5); wdata = '0;
    @(negedge clk);
    start = 1'b0;
    len = 1;
    repeat (2) begin @(negedge clk); len++; end
    start = 1'b1; op = 2'd1; addr = AW'(6); wdata = 8'hEE;
    @(negedge clk); len++;
    start = 1'b0;
    while (!done) begin @(negedge clk); len++; end
    chk(len == LEN_PLAIN, "R8 done at expected cycle", len, LEN_PLAIN);
    chk(rdata == model[5], "R10 running access unchanged", rdata, model[5]);
    @(negedge clk);
    chk(!busy && !done, "R8 busy drops after done", {busy, done}, 0);
    repeat (3) @(negedge clk);
    chk(!busy, "R10 no second access", busy, 0);
    access(2'd0, 6, '0, '0, len);
    chk(rdata == model[6], "R10 ignored write not stored", rdata, model[6]);

    // R11 core planes: half-select and inhibit keep state
    @(negedge clk);
    px = 4'b0010; py = 4'b0100; pset = 1'b1; pinh = 8'h00;
    @(negedge clk);
    pset = 1'b0; px = 4'b0010; py = 4'b0000; prst = 1'b1;
    @(negedge clk);
    chk(psense == 8'h00, "R11 half-select no sense", psense, 0);
    px = 4'b0000; py = 4'b0100;
    @(negedge clk);
    prst = 1'b0; px = 4'b0001; py = 4'b0000; pset = 1'b1;
    @(negedge clk);
    px = 4'b0001; py = 4'b1000; pset = 1'b1; pinh = 8'hFF;
    @(negedge clk);
    pset = 1'b0; pinh = 8'h00; px = 4'b0010; py = 4'b0100; prst = 1'b1;
    #1;
    chk(psense == 8'hFF, "R11 half-selected core kept", psense, 8'hFF);
    @(negedge clk);
    chk(psense == 8'h00, "R11 clearing drive clears", psense, 0);
    px = 4'b0001; py = 4'b0000;
    @(negedge clk);
    px = 4'b0001; py = 4'b1000;
    #1;
    chk(psense == 8'h00, "R11 inhibit and half-select keep zero", psense, 0);
    @(negedge clk);
    prst = 1'b0; px = '0; py = '0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule